// File: doc/BRIEF.md
# Instruction Fetch Cache with Sweep Invalidation

This block sits between an instruction fetch port and a slower memory port. It holds 8 KB of read-only code in a set-associative array of 32-byte lines, with 2 ways by default and 4 as the other supported setting. A fetch that hits is answered from the array. A fetch that misses pulls the whole enclosing line from memory, one word per beat, and then allocates it.

A small control register steers the cache. Software writes its invalidate bit to start a sweep that clears one set per clock. The bit drops by itself when the last set has been cleared. If a line refill is in flight when the sweep is requested, that refill is not allocated and a sticky abort flag records it. The enable bit only takes effect once no sweep is running. Per-way lock bits keep chosen ways resident by removing them from victim selection.

After reset the cache is off, and every fetch becomes a single-word memory read.

Top module: `ic_fetch_cache`

## Requirements
- R1: After reset the control register reads all zero: enable (bit 0), sweep-busy/invalidate (bit 1), abort (bit 2), reserved bit 3, lock mask (bits 4 and up, one per way). No fetch response and no memory request are active.
- R2: While enable is 0, every fetch is served by one single-word memory read (`m_burst`=0 at the word address) and allocates nothing. Lines already resident are hit again once enable returns to 1.
- R3: Writing 1 to bit 1 while no sweep runs starts a sweep. Bit 1 then reads 1 for exactly SETS clocks, one set cleared per clock, and then clears itself. Writing bit 1 while a sweep runs does not restart or lengthen it. Writing 0 to bit 1 has no effect.
- R4: While a sweep runs, including the cycle it is requested, fetches bypass the array as single-word reads and allocate nothing. After the sweep every previously resident line misses.
- R5: With enable 1 and no sweep, a miss issues one line request (`m_burst`=1, line-aligned address) of WORDS beats delivered in address order. It returns the requested word and allocates the line. With the default configuration the word offset is address bits [4:2], the set is bits [11:5] and the tag is bits [31:12].
- R6: A fetch that hits returns the stored word with no memory request. `f_valid` is a one-cycle pulse in the second cycle after the request is first sampled.
- R7: On a miss the victim is picked round-robin per set, starting from the way after the one last filled in that set.
- R8: A way whose lock bit is 1 is never chosen as a refill victim, and its lines keep hitting. When every way is locked, a miss is served as a single-word read without allocation.
- R9: An invalidate request accepted while a line refill is in progress sets abort (bit 2). The refill still returns the correct word to the fetch port, but its line is not allocated.
- R10: Abort stays set after the sweep completes. It is cleared by the next accepted invalidate request made while no refill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_req | input | 1 | Fetch request, held until `f_valid` |
| f_addr | input | ADDR_W | Fetch byte address, word aligned |
| f_valid | output | 1 | One-cycle response pulse |
| f_data | output | DATA_W | Fetched instruction word |
| m_req | output | 1 | Memory request, held until its last beat |
| m_burst | output | 1 | 1: whole-line read, 0: single-word read |
| m_addr | output | ADDR_W | Memory byte address (line or word aligned) |
| m_rvalid | input | 1 | Memory read beat valid |
| m_rdata | input | DATA_W | Memory read beat data |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4+WAYS | Control register write data |
| cfg_rdata | output | 4+WAYS | Control register read data |

## Verification
The sharpest collision is an invalidate request that lands in the middle of a line refill. Here the sweep start, the abort flag and the allocation of the refilled line all compete in the same cycle. The bench starts a miss and, a few cycles later while the beats are still arriving, writes the invalidate bit. It then checks three things: the fetch still returns the right word, the abort flag reads 1, and after the sweep the same address needs a fresh line refill, which proves the aborted line was never allocated. A second overlap, a new invalidate write during a running sweep, is judged by measuring that the busy bit still stays high for exactly SETS cycles.

// File: rtl/icache_pkg.sv
// Shared definitions for the instruction fetch cache.
// Assumes: control register field positions are fixed here and used by both
// the control register and the bench-facing documentation.
package icache_pkg;
    // Top-level sequencing states of the fetch path.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BYP  = 2'd2,
        ST_RESP = 2'd3
    } ic_state_t;

    localparam int CTL_EN       = 0;
    localparam int CTL_INV      = 1;
    localparam int CTL_ABT      = 2;
    localparam int CTL_LOCK_LSB = 4;
endpackage

// File: rtl/ic_ctrl_reg.sv
// Control register and invalidate sweep sequencer.
// Holds enable, lock mask, sweep-busy and the sticky abort flag. A sweep walks
// set indices from 0 to SETS-1, one per clock, then drops the busy bit.
// Assumes: SETS is a power of two and SET_W = log2(SETS).
module ic_ctrl_reg import icache_pkg::*; #(
    parameter int WAYS  = 2,
    parameter int SETS  = 128,
    parameter int SET_W = 7,
    parameter int CFG_W = CTL_LOCK_LSB + WAYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             fill_busy,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             enable,
    output logic             inval_busy,
    output logic             inv_start,
    output logic [SET_W-1:0] sweep_set,
    output logic [WAYS-1:0]  lock
);
    logic             en_q;
    logic             inv_q;
    logic             abt_q;
    logic [WAYS-1:0]  lock_q;
    logic [SET_W-1:0] cnt_q;

    // A new sweep is accepted only when none is running.
    assign inv_start = cfg_we & cfg_wdata[CTL_INV] & ~inv_q;

    // Software-written fields: enable and lock mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= '0;
        end else if (cfg_we) begin
            en_q   <= cfg_wdata[CTL_EN];
            lock_q <= cfg_wdata[CTL_LOCK_LSB +: WAYS];
        end
    end

    // Sweep sequencer: busy bit and set counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
            cnt_q <= '0;
        end else if (inv_start) begin
            inv_q <= 1'b1;
            cnt_q <= '0;
        end else if (inv_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == SET_W'(SETS - 1)) begin
                inv_q <= 1'b0;
            end
        end
    end

    // Abort flag: set or cleared at each accepted invalidate request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abt_q <= 1'b0;
        end else if (inv_start) begin
            abt_q <= fill_busy;
        end
    end

    // Read view of the register.
    always_comb begin
        cfg_rdata                         = '0;
        cfg_rdata[CTL_EN]                 = en_q;
        cfg_rdata[CTL_INV]                = inv_q;
        cfg_rdata[CTL_ABT]                = abt_q;
        cfg_rdata[CTL_LOCK_LSB +: WAYS]   = lock_q;
    end

    assign enable     = en_q;
    assign inval_busy = inv_q;
    assign sweep_set  = cnt_q;
    assign lock       = lock_q;

    // R3: the busy bit only drops after the last set has been swept.
    a_r3_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inv_q) |-> ($past(cnt_q) == SET_W'(SETS - 1)));
endmodule

// File: rtl/ic_tag_store.sv
// Tag and valid storage with hit detection and victim choice.
// One tag array and one valid vector per way, a round-robin pointer per set.
// The victim is the first unlocked way at or after the set's pointer.
// Assumes: WAYS is a power of two, so pointer arithmetic wraps naturally.
module ic_tag_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 128,
    parameter int SET_W = 7,
    parameter int TAG_W = 20,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [WAYS-1:0]  lock,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             vic_ok,
    output logic [WAY_W-1:0] vic_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             sw_en,
    input  logic [SET_W-1:0] sw_set
);
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] rr_q [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_q;

        // Tag write on allocation.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        // Valid bits: cleared by reset and sweep, set by allocation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (sw_en) begin
                vld_q[sw_set] <= 1'b0;
            end else if (wr_en && wr_way == WAY_W'(w)) begin
                vld_q[wr_set] <= 1'b1;
            end
        end

        assign hit_vec[w] = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);
    end

    // Encode the hitting way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
    assign hit = |hit_vec;

    // Round-robin pointer per set, advanced past each filled way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (wr_en) begin
            rr_q[wr_set] <= wr_way + 1'b1;
        end
    end

    // First unlocked way starting from the pointer.
    always_comb begin
        logic [WAY_W-1:0] cand;
        vic_ok  = 1'b0;
        vic_way = rr_q[lk_set];
        for (int k = WAYS - 1; k >= 0; k--) begin
            cand = rr_q[lk_set] + WAY_W'(k);
            if (!lock[cand]) begin
                vic_way = cand;
                vic_ok  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ic_data_store.sv
// Instruction word storage, one bank per way.
// Written one word per refill beat, read combinationally at the fetch address.
// Assumes: index is {set, word offset}, SETS*WORDS words per way.
module ic_data_store #(
    parameter int WAYS   = 2,
    parameter int SETS   = 128,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int SET_W  = 7,
    parameter int OFF_W  = 3,
    parameter int WAY_W  = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = SETS * WORDS;

    logic [DATA_W-1:0] rd_vec [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store one refill beat.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                mem[{wr_set, wr_off}] <= wr_data;
            end
        end

        assign rd_vec[w] = mem[{rd_set, rd_off}];
    end

    assign rd_data = rd_vec[rd_way];
endmodule

// File: rtl/ic_fetch_cache.sv
// Read-only instruction cache between a fetch port and a memory port.
// One request outstanding at a time: a hit answers from the array, a miss
// refills a full line, and a disabled, sweeping or fully locked cache turns
// the fetch into a single-word memory read. Responses are one-cycle pulses.
// Assumes: the requester holds f_req/f_addr until f_valid; memory returns
// beats in address order while m_req is high.
module ic_fetch_cache import icache_pkg::*; #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 2,
    localparam int CFG_W      = CTL_LOCK_LSB + WAYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_req,
    input  logic [ADDR_W-1:0] f_addr,
    output logic              f_valid,
    output logic [DATA_W-1:0] f_data,
    output logic              m_req,
    output logic              m_burst,
    output logic [ADDR_W-1:0] m_addr,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BYTE_W     = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W      = $clog2(WORDS);
    localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W      = ADDR_W - BYTE_W - OFF_W - SET_W;

    ic_state_t         state_q;
    logic [ADDR_W-1:0] req_q;
    logic [WAY_W-1:0]  fill_way_q;
    logic              alloc_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] rsp_q;

    logic              enable, inval_busy, inv_start;
    logic [SET_W-1:0]  sweep_set;
    logic [WAYS-1:0]   lock;
    logic              hit, vic_ok;
    logic [WAY_W-1:0]  hit_way, vic_way;
    logic [DATA_W-1:0] arr_data;
    logic              cache_on, last_beat, data_we, tag_wr;

    logic [OFF_W-1:0]  f_off, r_off;
    logic [SET_W-1:0]  f_set, r_set;
    logic [TAG_W-1:0]  f_tag, r_tag;

    assign f_off = f_addr[BYTE_W +: OFF_W];
    assign f_set = f_addr[BYTE_W + OFF_W +: SET_W];
    assign f_tag = f_addr[BYTE_W + OFF_W + SET_W +: TAG_W];
    assign r_off = req_q[BYTE_W +: OFF_W];
    assign r_set = req_q[BYTE_W + OFF_W +: SET_W];
    assign r_tag = req_q[BYTE_W + OFF_W + SET_W +: TAG_W];

    ic_ctrl_reg #(
        .WAYS (WAYS), .SETS (SETS), .SET_W (SET_W), .CFG_W (CFG_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .fill_busy  (state_q == ST_FILL),
        .cfg_rdata  (cfg_rdata),
        .enable     (enable),
        .inval_busy (inval_busy),
        .inv_start  (inv_start),
        .sweep_set  (sweep_set),
        .lock       (lock)
    );

    ic_tag_store #(
        .WAYS (WAYS), .SETS (SETS), .SET_W (SET_W), .TAG_W (TAG_W), .WAY_W (WAY_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (f_set),
        .lk_tag  (f_tag),
        .lock    (lock),
        .hit     (hit),
        .hit_way (hit_way),
        .vic_ok  (vic_ok),
        .vic_way (vic_way),
        .wr_en   (tag_wr),
        .wr_set  (r_set),
        .wr_way  (fill_way_q),
        .wr_tag  (r_tag),
        .sw_en   (inval_busy),
        .sw_set  (sweep_set)
    );

    ic_data_store #(
        .WAYS (WAYS), .SETS (SETS), .WORDS (WORDS), .DATA_W (DATA_W),
        .SET_W (SET_W), .OFF_W (OFF_W), .WAY_W (WAY_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (data_we),
        .wr_way  (fill_way_q),
        .wr_set  (r_set),
        .wr_off  (beat_q),
        .wr_data (m_rdata),
        .rd_set  (f_set),
        .rd_off  (f_off),
        .rd_way  (hit_way),
        .rd_data (arr_data)
    );

    // The array is usable only when enabled and no sweep is running or starting.
    assign cache_on  = enable & ~inval_busy & ~inv_start;
    assign last_beat = (beat_q == OFF_W'(WORDS - 1));
    assign data_we   = (state_q == ST_FILL) & m_rvalid;
    assign tag_wr    = data_we & last_beat & alloc_q & ~inv_start;

    // Fetch sequencer: lookup, refill, bypass and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            fill_way_q <= '0;
            alloc_q    <= 1'b0;
            beat_q     <= '0;
            rsp_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (f_req) begin
                        req_q <= f_addr;
                        if (cache_on && hit) begin
                            rsp_q   <= arr_data;
                            state_q <= ST_RESP;
                        end else if (cache_on && vic_ok) begin
                            fill_way_q <= vic_way;
                            alloc_q    <= 1'b1;
                            beat_q     <= '0;
                            state_q    <= ST_FILL;
                        end else begin
                            state_q <= ST_BYP;
                        end
                    end
                end
                ST_FILL: begin
                    if (inv_start) alloc_q <= 1'b0;
                    if (m_rvalid) begin
                        if (beat_q == r_off) rsp_q <= m_rdata;
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) state_q <= ST_RESP;
                    end
                end
                ST_BYP: begin
                    if (m_rvalid) begin
                        rsp_q   <= m_rdata;
                        state_q <= ST_RESP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port view of the current state.
    always_comb begin
        m_req   = (state_q == ST_FILL) || (state_q == ST_BYP);
        m_burst = (state_q == ST_FILL);
        if (state_q == ST_FILL) m_addr = req_q & ~ADDR_W'(LINE_BYTES - 1);
        else                    m_addr = req_q & ~ADDR_W'(WORD_BYTES - 1);
    end

    assign f_valid = (state_q == ST_RESP);
    assign f_data  = rsp_q;

    // Assertions next to the sequencer they guard.
    logic [WAYS-1:0] fill_oh;
    assign fill_oh = WAYS'(1) << fill_way_q;

    // R2: a request seen while disabled turns into a single-word read.
    a_r2_disabled_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && f_req && !enable) |=> (m_req && !m_burst));

    // R4: no line is allocated while a sweep is running.
    a_r4_no_alloc_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr |-> !inval_busy);

    // R5: a line request ends only after its final beat.
    a_r5_full_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(m_req) && $past(m_burst)) |-> ($past(beat_q) == OFF_W'(WORDS - 1)));

    // R6: the fetch response is a single-cycle pulse.
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |=> !f_valid);

    // R8: a refill never starts into a way that was locked when it was chosen.
    a_r8_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && $past(state_q) == ST_IDLE) |-> (($past(lock) & fill_oh) == '0));

    // R9: abort only rises out of an in-flight refill.
    a_r9_abort_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rdata[CTL_ABT]) |-> ($past(state_q) == ST_FILL));
endmodule

// File: tb/tb_ic_fetch_cache.sv
`timescale 1ns/1ps
module tb_ic_fetch_cache;
    localparam int SETS = 128;
    localparam int WORDS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_req = 1'b0;
    logic [31:0] f_addr = '0;
    logic        f_valid;
    logic [31:0] f_data;
    logic        m_req, m_burst;
    logic [31:0] m_addr;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic [5:0]  cfg_rdata;

    int total = 0;
    int bad = 0;
    int n_line = 0;
    int n_single = 0;

    always #2 clk = ~clk;

    ic_fetch_cache dut (
        .clk (clk), .rst_n (rst_n),
        .f_req (f_req), .f_addr (f_addr), .f_valid (f_valid), .f_data (f_data),
        .m_req (m_req), .m_burst (m_burst), .m_addr (m_addr),
        .m_rvalid (m_rvalid), .m_rdata (m_rdata),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata)
    );

    function automatic logic [31:0] memfn(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F0F_3C3C;
    endfunction

    function automatic logic [31:0] mk(int tag, int set, int off);
        return 32'((tag << 12) | (set << 5) | (off << 2));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Memory model: latency 2, then one beat per cycle.
    initial begin
        logic [31:0] base;
        int n;
        forever begin
            @(negedge clk);
            m_rvalid = 1'b0;
            if (m_req) begin
                base = m_addr;
                n = m_burst ? WORDS : 1;
                if (m_burst) n_line++; else n_single++;
                repeat (2) @(negedge clk);
                for (int k = 0; k < n; k++) begin
                    m_rvalid = 1'b1;
                    m_rdata  = memfn(base + 32'(4 * k));
                    @(negedge clk);
                end
                m_rvalid = 1'b0;
                @(negedge clk);
            end
        end
    end

    task automatic cfg_write(logic [5:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fetch(logic [31:0] a, output logic [31:0] d, output int dl, output int ds);
        int l0 = n_line;
        int s0 = n_single;
        f_addr = a;
        f_req = 1'b1;
        do @(negedge clk); while (!f_valid);
        d = f_data;
        f_req = 1'b0;
        dl = n_line - l0;
        ds = n_single - s0;
    endtask

    task automatic xfetch(string req, logic [31:0] a, int exp_line, int exp_single);
        logic [31:0] d;
        int dl, ds;
        fetch(a, d, dl, ds);
        chk({req, " data"}, d, memfn(a));
        chk({req, " line reads"}, 32'(dl), 32'(exp_line));
        chk({req, " single reads"}, 32'(ds), 32'(exp_single));
    endtask

    task automatic wait_sweep();
        while (cfg_rdata[1]) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        int cnt;
        logic [31:0] d;
        int dl, ds;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 cfg", 32'(cfg_rdata), 32'h0);
        chk("R1 f_valid", 32'(f_valid), 32'h0);
        chk("R1 m_req", 32'(m_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, all fetches are single reads
        xfetch("R2 off a", mk(1, 0, 0), 0, 1);
        xfetch("R2 off b", mk(7, 33, 5), 0, 1);
        xfetch("R2 off repeat", mk(1, 0, 0), 0, 1);

        // R3: sweep length and self-clear
        cfg_write(6'h02);
        chk("R3 busy set", 32'(cfg_rdata[1]), 32'h1);
        cnt = 0;
        while (cfg_rdata[1]) begin cnt++; @(negedge clk); end
        chk("R3 sweep cycles", 32'(cnt), 32'(SETS));
        chk("R3 cfg after", 32'(cfg_rdata), 32'h0);
        cfg_write(6'h00);
        chk("R3 write zero inv", 32'(cfg_rdata[1]), 32'h0);

        // R5 / R6: fill every set, then hit every word
        cfg_write(6'h01);
        for (int s = 0; s < SETS; s++) begin
            xfetch("R5 miss", mk(5, s, s % WORDS), 1, 0);
            for (int o = 0; o < WORDS; o++) xfetch("R6 hit", mk(5, s, o), 0, 0);
        end

        // R7: round-robin in set 9 (way0 holds tag5, pointer at way1)
        xfetch("R7 x0 fill", mk(1, 9, 0), 1, 0);
        xfetch("R7 x1 fill", mk(2, 9, 1), 1, 0);
        xfetch("R7 x2 fill", mk(3, 9, 2), 1, 0);
        xfetch("R7 x1 kept", mk(2, 9, 1), 0, 0);
        xfetch("R7 x0 evicted", mk(1, 9, 0), 1, 0);
        xfetch("R7 x2 kept", mk(3, 9, 2), 0, 0);
        xfetch("R7 x0 kept", mk(1, 9, 0), 0, 0);
        xfetch("R7 x1 evicted", mk(2, 9, 1), 1, 0);

        // R8: lock way0 (holds tag5) in set 20
        cfg_write(6'h11);
        xfetch("R8 y0 fill", mk(1, 20, 3), 1, 0);
        xfetch("R8 y1 fill", mk(2, 20, 4), 1, 0);
        xfetch("R8 locked hit", mk(5, 20, 4), 0, 0);
        xfetch("R8 y1 hit", mk(2, 20, 4), 0, 0);
        xfetch("R8 y0 evicted", mk(1, 20, 3), 1, 0);
        cfg_write(6'h31);
        xfetch("R8 all locked", mk(3, 20, 6), 0, 1);
        xfetch("R8 all locked again", mk(3, 20, 6), 0, 1);
        xfetch("R8 y0 hit locked", mk(1, 20, 3), 0, 0);
        xfetch("R8 t5 hit locked", mk(5, 20, 0), 0, 0);

        // R2: disable keeps contents, re-enable hits
        cfg_write(6'h00);
        xfetch("R2 disabled resident", mk(1, 20, 3), 0, 1);
        cfg_write(6'h01);
        xfetch("R2 reenabled hit", mk(1, 20, 3), 0, 0);

        // R4: fetches during a sweep bypass and allocate nothing
        cfg_write(6'h03);
        xfetch("R4 sweep resident", mk(1, 20, 3), 0, 1);
        xfetch("R4 sweep new", mk(9, 40, 1), 0, 1);
        wait_sweep();
        chk("R4 cfg after", 32'(cfg_rdata), 32'h01);
        xfetch("R4 new misses", mk(9, 40, 1), 1, 0);
        xfetch("R4 old misses", mk(1, 20, 3), 1, 0);

        // R9: invalidate during a refill
        fork
            begin
                fetch(mk(11, 60, 6), d, dl, ds);
            end
            begin
                repeat (4) @(negedge clk);
                cfg_write(6'h03);
            end
        join
        chk("R9 data", d, memfn(mk(11, 60, 6)));
        chk("R9 line read", 32'(dl), 32'h1);
        chk("R9 abort set", 32'(cfg_rdata[2]), 32'h1);
        wait_sweep();
        chk("R10 abort sticky", 32'(cfg_rdata[2]), 32'h1);
        xfetch("R9 not allocated", mk(11, 60, 6), 1, 0);
        xfetch("R9 refilled hit", mk(11, 60, 6), 0, 0);

        // R10 / R3: clear abort, rewrite during sweep does not restart it
        cfg_write(6'h03);
        chk("R10 abort cleared", 32'(cfg_rdata[2]), 32'h0);
        cnt = 0;
        while (cfg_rdata[1]) begin
            if (cnt == 10) begin cfg_we = 1'b1; cfg_wdata = 6'h03; end
            else cfg_we = 1'b0;
            cnt++;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk("R3 rewrite sweep cycles", 32'(cnt), 32'(SETS));
        chk("R10 abort stays clear", 32'(cfg_rdata[2]), 32'h0);
        xfetch("R4 after second sweep", mk(11, 60, 6), 1, 0);

        finish_run();
    end
endmodule